// File: doc/BRIEF.md
# Conditional Trap Compare Unit

This block decides whether a conditional trap instruction fires. It receives two operands, a five-bit condition mask and a width select. Five relations between the operands are worked out side by side: signed less-than, signed greater-than, equality, unsigned less-than and unsigned greater-than. The mask enables any subset of them. When at least one enabled relation holds for a qualified evaluation, the unit emits a one-cycle trap request together with a fixed program-exception subtype code.

In narrow mode only the low half of each operand takes part, read either as a signed or as an unsigned value of half width. In wide mode the full operand width is compared. Decoding the instruction and delivering the resulting exception are left to the surrounding pipeline. A valid strobe marks each evaluation, and the result is registered. Two parameters set the operand width and the comparator style, which is either direct relational operators or shared subtractors with borrow logic.

Top module: `trap_cmp_unit`

## Requirements
- R1: While reset is asserted and on the first edges after it, `trap_req` is 0 and `trap_code` is all zeros.
- R2: Mask bit 4 enables a trap when `op_a` is less than `op_b` as two's-complement values.
- R3: Mask bit 3 enables a trap when `op_a` is greater than `op_b` as two's-complement values.
- R4: Mask bit 2 enables a trap when `op_a` equals `op_b` over the compared width.
- R5: Mask bit 1 enables a trap when `op_a` is less than `op_b` as unsigned values.
- R6: Mask bit 0 enables a trap when `op_a` is greater than `op_b` as unsigned values.
- R7: With `wide_sel` = 0 only bits 31:0 of each operand are compared, as 32-bit signed or unsigned values. Bits 63:32 have no effect on the result.
- R8: With `wide_sel` = 1 all 64 bits of each operand are compared.
- R9: A mask of 0 never produces a trap. A mask of 5'b11111 always produces one for a valid evaluation.
- R10: `trap_req` is high in exactly the cycle after an edge that sampled `in_valid` = 1 with a matching condition. It is never high after an edge that sampled `in_valid` = 0.
- R11: While `trap_req` is high, `trap_code` equals the parameter TRAP_CODE (default 8'h40). Otherwise `trap_code` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies the operands, mask and width select for one evaluation |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| cond_mask | input | 5 | Relation enables: bit4 signed lt, bit3 signed gt, bit2 eq, bit1 unsigned lt, bit0 unsigned gt |
| wide_sel | input | 1 | 1 compares full width, 0 compares the low 32 bits |
| trap_req | output | 1 | One-cycle trap request |
| trap_code | output | 8 | Program-exception trap subtype, zero when no request |

## Verification
A signed relation and an unsigned relation can both be true for the same operand pair in one evaluation, and they can disagree. For example, with A = -1 and B = 1, signed less-than and unsigned greater-than both hold. The sweep provokes this with operand sets that straddle the sign boundary in both widths, including values whose upper half would reverse the result in narrow mode. Each of the 32 masks is applied to every pair. The bench judges the outcome by computing each relation arithmetically from the extended operands and ORing only the enabled ones. A mask that picks one relation of the pair must then trap or stay quiet on that relation alone.

// File: rtl/trap_cmp_pkg.sv
package trap_cmp_pkg;
   // relation positions inside the condition mask; the decoder relies on them
   localparam int REL_N   = 5;
   localparam int REL_SLT = 4;
   localparam int REL_SGT = 3;
   localparam int REL_EQ  = 2;
   localparam int REL_ULT = 1;
   localparam int REL_UGT = 0;

   typedef logic [REL_N-1:0] rel_vec_t;

   // comparator implementation variants
   localparam int CMP_DIRECT   = 0;
   localparam int CMP_SUBTRACT = 1;
endpackage

// File: rtl/trap_operand_fmt.sv
// Extends operands for the compare stage: the low half is sign- or
// zero-extended in narrow mode, or passed through in wide mode.
module trap_operand_fmt #(
   parameter int DATA_W = 64,
   parameter int HALF_W = 32
) (
   input  logic [DATA_W-1:0] raw_a,
   input  logic [DATA_W-1:0] raw_b,
   input  logic              wide,
   output logic [DATA_W-1:0] sx_a,
   output logic [DATA_W-1:0] sx_b,
   output logic [DATA_W-1:0] zx_a,
   output logic [DATA_W-1:0] zx_b
);
   localparam int EXT_W = DATA_W - HALF_W;

   logic [DATA_W-1:0] nar_sa, nar_sb, nar_za, nar_zb;

   always_comb begin
      nar_sa = {{EXT_W{raw_a[HALF_W-1]}}, raw_a[HALF_W-1:0]};
      nar_sb = {{EXT_W{raw_b[HALF_W-1]}}, raw_b[HALF_W-1:0]};
      nar_za = {{EXT_W{1'b0}}, raw_a[HALF_W-1:0]};
      nar_zb = {{EXT_W{1'b0}}, raw_b[HALF_W-1:0]};
   end

   assign sx_a = wide ? raw_a : nar_sa;
   assign sx_b = wide ? raw_b : nar_sb;
   assign zx_a = wide ? raw_a : nar_za;
   assign zx_b = wide ? raw_b : nar_zb;
endmodule

// File: rtl/trap_relation_cmp.sv
// Produces the five relation flags; CMP_STYLE picks the implementation.
module trap_relation_cmp
   import trap_cmp_pkg::*;
#(
   parameter int W         = 64,
   parameter int CMP_STYLE = CMP_SUBTRACT
) (
   input  logic [W-1:0] sx_a,
   input  logic [W-1:0] sx_b,
   input  logic [W-1:0] zx_a,
   input  logic [W-1:0] zx_b,
   output rel_vec_t     rel
);
   logic s_lt, u_lt, eq;

   assign eq = (zx_a == zx_b);

   generate
      if (CMP_STYLE == CMP_DIRECT) begin : g_direct
         assign s_lt = ($signed(sx_a) < $signed(sx_b));
         assign u_lt = (zx_a < zx_b);
      end else begin : g_subtract
         logic [W:0] s_diff, u_diff;
         assign s_diff = {1'b0, sx_a} - {1'b0, sx_b};
         assign u_diff = {1'b0, zx_a} - {1'b0, zx_b};
         // a borrow means unsigned less; differing sign bits flip it
         assign s_lt = s_diff[W] ^ sx_a[W-1] ^ sx_b[W-1];
         assign u_lt = u_diff[W];
      end
   endgenerate

   always_comb begin
      rel          = '0;
      rel[REL_SLT] = s_lt;
      rel[REL_SGT] = ~s_lt & ~eq;
      rel[REL_EQ]  = eq;
      rel[REL_ULT] = u_lt;
      rel[REL_UGT] = ~u_lt & ~eq;
   end
endmodule

// File: rtl/trap_decide.sv
// Combines enabled relations into a single trap decision.
module trap_decide
   import trap_cmp_pkg::*;
(
   input  logic     valid,
   input  rel_vec_t mask,
   input  rel_vec_t rel,
   output logic     hit
);
   assign hit = valid & (|(mask & rel));
endmodule

// File: rtl/trap_cmp_unit.sv
module trap_cmp_unit
   import trap_cmp_pkg::*;
#(
   parameter int          DATA_W    = 64,
   parameter int          HALF_W    = DATA_W / 2,
   parameter int          CODE_W    = 8,
   parameter logic [7:0]  TRAP_CODE = 8'h40,
   parameter int          CMP_STYLE = CMP_SUBTRACT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [REL_N-1:0]  cond_mask,
   input  logic              wide_sel,
   output logic              trap_req,
   output logic [CODE_W-1:0] trap_code
);
   localparam logic [CODE_W-1:0] CODE_VAL = CODE_W'(TRAP_CODE);

   generate
      if (HALF_W * 2 != DATA_W) begin : g_bad_half
         $error("HALF_W must be half of DATA_W");
      end
      if (CODE_W < 1 || CODE_W > 8) begin : g_bad_code
         $error("CODE_W must be 1..8");
      end
      if (CMP_STYLE != CMP_DIRECT && CMP_STYLE != CMP_SUBTRACT) begin : g_bad_style
         $error("unknown CMP_STYLE");
      end
   endgenerate

   logic [DATA_W-1:0] sx_a, sx_b, zx_a, zx_b;
   rel_vec_t          rel;
   logic              hit;

   trap_operand_fmt #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_fmt (
      .raw_a(op_a), .raw_b(op_b), .wide(wide_sel),
      .sx_a(sx_a), .sx_b(sx_b), .zx_a(zx_a), .zx_b(zx_b)
   );

   trap_relation_cmp #(.W(DATA_W), .CMP_STYLE(CMP_STYLE)) u_cmp (
      .sx_a(sx_a), .sx_b(sx_b), .zx_a(zx_a), .zx_b(zx_b), .rel(rel)
   );

   trap_decide u_dec (
      .valid(in_valid), .mask(cond_mask), .rel(rel), .hit(hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trap_req  <= 1'b0;
         trap_code <= '0;
      end else begin
         trap_req  <= hit;
         trap_code <= hit ? CODE_VAL : '0;
      end
   end
endmodule

// File: rtl/trap_cmp_unit_chk.sv
module trap_cmp_unit_chk #(
   parameter int         DATA_W    = 64,
   parameter int         HALF_W    = 32,
   parameter int         CODE_W    = 8,
   parameter logic [7:0] TRAP_CODE = 8'h40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] op_a,
   input logic [DATA_W-1:0] op_b,
   input logic [4:0]        cond_mask,
   input logic              wide_sel,
   input logic              trap_req,
   input logic [CODE_W-1:0] trap_code
);
   AST_REQ_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> $past(in_valid)); // R10
   AST_ZERO_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> ($past(cond_mask) != 5'd0)); // R9
   AST_FULL_MASK_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cond_mask == 5'h1F) |=> trap_req); // R9
   AST_CODE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_req |-> (trap_code == '0)); // R11
   AST_CODE_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (trap_code == CODE_W'(TRAP_CODE))); // R11
   AST_WIDE_EQ_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cond_mask[2] && wide_sel && op_a == op_b) |=> trap_req); // R4
   AST_NARROW_EQ_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cond_mask[2] && !wide_sel &&
       op_a[HALF_W-1:0] == op_b[HALF_W-1:0]) |=> trap_req); // R7
endmodule

bind trap_cmp_unit trap_cmp_unit_chk #(
   .DATA_W(DATA_W), .HALF_W(HALF_W), .CODE_W(CODE_W), .TRAP_CODE(TRAP_CODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
   .cond_mask(cond_mask), .wide_sel(wide_sel), .trap_req(trap_req),
   .trap_code(trap_code)
);

// File: tb/test_trap_cmp_unit.sv
`timescale 1ns/1ps
module test_trap_cmp_unit;
   localparam logic [7:0] CODE = 8'h40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] op_a = '0, op_b = '0;
   logic [4:0]  cond_mask = '0;
   logic        wide_sel = 1'b0;
   logic        trap_req;
   logic [7:0]  trap_code;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   trap_cmp_unit i_trap_cmp_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .cond_mask(cond_mask), .wide_sel(wide_sel), .trap_req(trap_req),
      .trap_code(trap_code)
   );

   function automatic bit model(input logic [63:0] a, input logic [63:0] b,
                                input logic [4:0] m, input bit wide);
      longint          sa, sb;
      longint unsigned ua, ub;
      if (wide) begin
         sa = longint'(a); sb = longint'(b); ua = a; ub = b;
      end else begin
         sa = longint'(int'(a[31:0])); sb = longint'(int'(b[31:0]));
         ua = longint'(a[31:0]) & 64'hFFFF_FFFF; ub = longint'(b[31:0]) & 64'hFFFF_FFFF;
      end
      return (m[4] && sa < sb) || (m[3] && sa > sb) || (m[2] && ua == ub) ||
             (m[1] && ua < ub) || (m[0] && ua > ub);
   endfunction

   task automatic check(input string tag, input logic [8:0] got, input logic [8:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s req/code got=%h exp=%h", tag, got, exp);
      end
   endtask

   // entered at a falling edge, leaves at a falling edge
   task automatic eval(input logic [63:0] a, input logic [63:0] b,
                       input logic [4:0] m, input bit wide, input bit exp,
                       input string tag);
      in_valid = 1'b1; op_a = a; op_b = b; cond_mask = m; wide_sel = wide;
      @(negedge clk);
      in_valid = 1'b0;
      check(tag, {trap_req, trap_code}, {exp, exp ? CODE : 8'h00});
      @(negedge clk);
      check("R10", {trap_req, trap_code}, 9'h000);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   logic [63:0] vals [8];

   initial begin
      vals[0] = 64'h0;
      vals[1] = 64'h1;
      vals[2] = 64'hFFFF_FFFF_FFFF_FFFF;
      vals[3] = 64'h7FFF_FFFF_FFFF_FFFF;
      vals[4] = 64'h8000_0000_0000_0000;
      vals[5] = 64'h0000_0000_8000_0000;
      vals[6] = 64'hFFFF_FFFF_0000_0001;
      vals[7] = 64'h0000_0001_7FFF_FFFF;

      repeat (3) @(negedge clk);
      check("R1", {trap_req, trap_code}, 9'h000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {trap_req, trap_code}, 9'h000);

      // A = -1, B = 1: signed less and unsigned greater both hold
      eval(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'b10000, 1'b1, 1'b1, "R2");
      eval(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'b01000, 1'b1, 1'b0, "R3");
      eval(64'h5, 64'hFFFF_FFFF_FFFF_FFFB, 5'b01000, 1'b1, 1'b1, "R3");
      eval(64'h1234, 64'h1234, 5'b00100, 1'b1, 1'b1, "R4");
      eval(64'h1234, 64'h1235, 5'b00100, 1'b1, 1'b0, "R4");
      eval(64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 5'b00010, 1'b1, 1'b1, "R5");
      eval(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'b00001, 1'b1, 1'b1, "R6");
      eval(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'b00010, 1'b1, 1'b0, "R6");
      // upper halves differ but low halves equal: narrow ignores them
      eval(64'hAAAA_0000_0000_0007, 64'h5555_0000_0000_0007, 5'b00100, 1'b0, 1'b1, "R7");
      eval(64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, 5'b00010, 1'b0, 1'b1, "R7");
      eval(64'h0000_0000_8000_0000, 64'h0, 5'b10000, 1'b0, 1'b1, "R7");
      eval(64'h0000_0000_8000_0000, 64'h0, 5'b10000, 1'b1, 1'b0, "R8");
      eval(64'h0000_0001_0000_0000, 64'h1, 5'b00001, 1'b1, 1'b1, "R8");
      eval(64'h3, 64'h9, 5'b00000, 1'b1, 1'b0, "R9");
      eval(64'h3, 64'h3, 5'b11111, 1'b0, 1'b1, "R9");
      eval(64'h9, 64'h3, 5'b11111, 1'b1, 1'b1, "R11");

      // idle cycles with matching inputs but no valid: no pulse
      in_valid = 1'b0; op_a = 64'h7; op_b = 64'h7; cond_mask = 5'h1F;
      @(negedge clk);
      check("R10", {trap_req, trap_code}, 9'h000);

      // back-to-back valids yield one result per cycle
      in_valid = 1'b1; op_a = 64'h1; op_b = 64'h2; cond_mask = 5'b00010; wide_sel = 1'b1;
      @(negedge clk);
      check("R10", {trap_req, trap_code}, {1'b1, CODE});
      op_a = 64'h2;
      @(negedge clk);
      in_valid = 1'b0;
      check("R10", {trap_req, trap_code}, 9'h000);
      @(negedge clk);

      // sweep: every pair, every mask, both widths
      for (int w = 0; w < 2; w++)
         for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
               for (int m = 0; m < 32; m++)
                  eval(vals[i], vals[j], 5'(m), w[0],
                       model(vals[i], vals[j], 5'(m), w[0]), w[0] ? "R8" : "R7");

      done = 1;
      summary();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog expired");
         summary();
      end
   end
endmodule